// File: doc/BRIEF.md
# Local Bus SRAM Cycle Controller

This block sits between an internal single-access request port and an external asynchronous-memory bus. Each accepted request becomes one external bus cycle on one chip-select area. Bits 28:26 of the physical address pick the area. The cycle runs through address setup, a strobe phase and an address hold phase. The length of each phase is programmed separately for every area.

A read drives an output-enable strobe and captures the returned data. A write drives only the byte-lane write strobes that the request enables and that the area's configured width allows. A bus-start pulse marks the first cycle of every access. An active-low ready input can stretch the strobe phase when the programmed wait count is nonzero.

Timing settings come in on a flat configuration vector with one field group per area. The block samples them when it accepts a request. A one-cycle done pulse returns the result to the requester, and a ready flag shows when a new request can be taken.

Top module: `sram_bus_ctrl`

## Requirements
- R1: Address bits 28:26 equal to 000 select area 0 and drive `bus_cs_n[0]` low for the whole access; 001 selects area 1 and drives `bus_cs_n[1]` low. At most one chip select is low at any time, and none is low while idle.
- R2: An address whose area value is NUM_AREAS or above is unmapped. It drives no chip select and no strobe. `done` rises one cycle after acceptance, with `rdata` equal to zero.
- R3: After acceptance, chip select and address are driven for exactly `setup` (0 to 7) cycles before any strobe is asserted.
- R4: The strobe phase lasts `wait`+1 cycles when ready does not stretch it. The wait field ranges from 0 to 25.
- R5: When the wait field is 0, `bus_rdy_n` is ignored. When it is nonzero, `bus_rdy_n` is sampled on the last planned strobe cycle. Each cycle in which it is sampled high adds one strobe cycle, with no upper limit.
- R6: After the strobe is released, chip select and address remain driven for exactly `hold` (0 to 7) cycles. The bus then returns to idle.
- R7: `bus_bs_n` is low in the first cycle of the access. It is also low in the second cycle when the bus-start hold bit is 1 and `setup` is 1 or more; otherwise it is high from the second cycle on.
- R8: A read holds `bus_rd_n` low during every strobe cycle and keeps all `bus_we_n` high. `bus_rdata` is captured on the last strobe cycle, masked to the lanes of the configured width, and presented on `rdata` together with `done`.
- R9: A write holds `bus_rd_n` high. During every strobe cycle, `bus_we_n[i]` is low exactly when `req_be[i]` is set and lane i lies inside the configured width. Width code 00 allows lane 0, 01 allows lanes 0 to 1, and 10 or 11 allow all four lanes.
- R10: `req_ready` is high only while idle, and a request is accepted when `req_valid` and `req_ready` are both high. `done` is a one-cycle pulse in the first idle cycle after the last bus cycle of the access.
- R11: Area k takes its fields from `cfg_area[14k+13:14k]`: setup in bits 2:0, wait in 7:3, hold in 10:8, bus-start hold in bit 11, width in 13:12. Wait values above 25 behave as 25.
- R12: `bus_addr` and `bus_wdata` stay stable from the first to the last cycle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | Physical address; bits 28:26 select the area |
| req_be | input | 4 | Byte-lane enables, bit i = lane i |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | High while idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid with `done` |
| cfg_area | input | 14*NUM_AREAS | Per-area timing and width fields |
| bus_addr | output | 29 | External address |
| bus_wdata | output | 32 | External write data |
| bus_rdata | input | 32 | External read data |
| bus_cs_n | output | NUM_AREAS | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe / output enable |
| bus_we_n | output | 4 | Active-low byte-lane write strobes |
| bus_bs_n | output | 1 | Active-low bus-start |
| bus_rdy_n | input | 1 | Active-low external ready |

## Verification
Numbering cycles from the first one after the accepting edge, strobes are due in cycles setup+1 through setup+wait+1+stretch. The access occupies setup+wait+1+stretch+hold cycles, and `done` with the captured `rdata` appears in the cycle after that. The bench computes these indices from the fields it programmed. It drives ready from the same cycle count, samples every output at the falling edge of each cycle, and compares each cycle against its expected window. This covers sweeps over all setup and hold values, several wait values and both ready behaviours.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    localparam int ADDR_W       = 29;
    localparam int DATA_W       = 32;
    localparam int LANES        = DATA_W / 8;
    localparam int AREA_SEL_LSB = 26;
    localparam int AREA_SEL_W   = 3;
    localparam int CFG_W        = 14;
    localparam int CNT_W        = 5;
    localparam logic [CNT_W-1:0] WAIT_LIMIT = 5'd25;

    typedef enum logic [1:0] {
        BW_8   = 2'b00,
        BW_16  = 2'b01,
        BW_32  = 2'b10,
        BW_RSV = 2'b11
    } bus_width_e;

    // packed layout, MSB first: width[13:12] bs_hold[11] hold[10:8] wait[7:3] setup[2:0]
    typedef struct packed {
        bus_width_e       width;
        logic             bs_hold;
        logic [2:0]       hold;
        logic [CNT_W-1:0] wait_cnt;
        logic [2:0]       setup;
    } area_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } cyc_state_e;

    function automatic logic [LANES-1:0] lanes_of(input bus_width_e w);
        case (w)
            BW_8:    lanes_of = 4'b0001;
            BW_16:   lanes_of = 4'b0011;
            default: lanes_of = 4'b1111;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] m);
        for (int i = 0; i < LANES; i++) begin
            lane_bits[i*8 +: 8] = {8{m[i]}};
        end
    endfunction

    function automatic logic [CNT_W-1:0] clamp_wait(input logic [CNT_W-1:0] w);
        clamp_wait = (w > WAIT_LIMIT) ? WAIT_LIMIT : w;
    endfunction

endpackage

// File: rtl/lbc_area_decode.sv
module lbc_area_decode
    import lbc_pkg::*;
#(
    parameter int NUM_AREAS = 2
) (
    input  logic [AREA_SEL_W-1:0]      sel,
    input  logic [NUM_AREAS*CFG_W-1:0] cfg_flat,
    output logic                       hit,
    output area_cfg_t                  cfg
);

    area_cfg_t cfg_arr [NUM_AREAS];

    for (genvar k = 0; k < NUM_AREAS; k++) begin : g_unpack
        assign cfg_arr[k] = area_cfg_t'(cfg_flat[k*CFG_W +: CFG_W]);
    end

    assign hit = ({1'b0, sel} < (AREA_SEL_W+1)'(NUM_AREAS));

    always_comb begin
        cfg = '0;
        for (int k = 0; k < NUM_AREAS; k++) begin
            if (sel == AREA_SEL_W'(k)) begin
                cfg = cfg_arr[k];
            end
        end
        cfg.wait_cnt = clamp_wait(cfg.wait_cnt);
    end

endmodule

// File: rtl/lbc_timing_fsm.sv
module lbc_timing_fsm
    import lbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       setup,
    input  logic [CNT_W-1:0] wait_cnt,
    input  logic [2:0]       hold,
    input  logic             bs_hold,
    input  logic             rdy_n,
    output cyc_state_e       state,
    output logic             strobe_last,
    output logic             last_cycle,
    output logic             bs_act
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wait_q;
    logic [2:0]       hold_q;
    logic             bs_ext;
    logic             stretch;

    // ready only matters when a nonzero wait was programmed
    assign stretch     = (wait_q != '0) && rdy_n;
    assign strobe_last = (state == ST_STROBE) && (cnt == '0) && !stretch;
    assign last_cycle  = (strobe_last && (hold_q == '0)) ||
                         ((state == ST_HOLD) && (cnt == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            wait_q <= '0;
            hold_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        wait_q <= wait_cnt;
                        hold_q <= hold;
                        if (setup != '0) begin
                            state <= ST_SETUP;
                            cnt   <= {2'b00, setup} - 5'd1;
                        end else begin
                            state <= ST_STROBE;
                            cnt   <= wait_cnt;
                        end
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        state <= ST_STROBE;
                        cnt   <= wait_q;
                    end else begin
                        cnt <= cnt - 5'd1;
                    end
                end
                ST_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 5'd1;
                    end else if (!stretch) begin
                        if (hold_q != '0) begin
                            state <= ST_HOLD;
                            cnt   <= {2'b00, hold_q} - 5'd1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 5'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // bus-start: first cycle, plus one more when enabled with a nonzero setup
    always_ff @(posedge clk) begin
        if (rst) begin
            bs_act <= 1'b0;
            bs_ext <= 1'b0;
        end else if (start) begin
            bs_act <= 1'b1;
            bs_ext <= bs_hold && (setup != '0);
        end else if (bs_ext) begin
            bs_ext <= 1'b0;
        end else begin
            bs_act <= 1'b0;
        end
    end

endmodule

// File: rtl/lbc_lane_ctrl.sv
module lbc_lane_ctrl
    import lbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              miss,
    input  logic              write,
    input  logic [LANES-1:0]  be,
    input  bus_width_e        width,
    input  logic              strobe,
    input  logic              strobe_last,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rd_n,
    output logic [LANES-1:0]  we_n,
    output logic [DATA_W-1:0] rdata
);

    logic             write_q;
    logic [LANES-1:0] lane_q;
    logic [LANES-1:0] wmask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            write_q <= 1'b0;
            lane_q  <= '0;
            wmask_q <= '0;
        end else if (start) begin
            write_q <= write;
            lane_q  <= lanes_of(width);
            wmask_q <= be & lanes_of(width);
        end
    end

    assign rd_n = !(strobe && !write_q);
    assign we_n = (strobe && write_q) ? ~wmask_q : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (miss) begin
            rdata <= '0;
        end else if (strobe_last && !write_q) begin
            rdata <= bus_rdata & lane_bits(lane_q);
        end
    end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import lbc_pkg::*;
#(
    parameter int NUM_AREAS = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [LANES-1:0]           req_be,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       req_ready,
    output logic                       done,
    output logic [DATA_W-1:0]          rdata,
    input  logic [NUM_AREAS*CFG_W-1:0] cfg_area,
    output logic [ADDR_W-1:0]          bus_addr,
    output logic [DATA_W-1:0]          bus_wdata,
    input  logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_AREAS-1:0]       bus_cs_n,
    output logic                       bus_rd_n,
    output logic [LANES-1:0]           bus_we_n,
    output logic                       bus_bs_n,
    input  logic                       bus_rdy_n
);

    logic                  accept;
    logic                  hit;
    logic                  start;
    logic                  miss;
    area_cfg_t             acfg;
    cyc_state_e            state;
    logic                  strobe_last;
    logic                  last_cycle;
    logic                  bs_act;
    logic                  busy;
    logic [AREA_SEL_W-1:0] area_q;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign start     = accept && hit;
    assign miss      = accept && !hit;
    assign busy      = (state != ST_IDLE);

    lbc_area_decode #(.NUM_AREAS(NUM_AREAS)) u_decode (
        .sel      (req_addr[AREA_SEL_LSB +: AREA_SEL_W]),
        .cfg_flat (cfg_area),
        .hit      (hit),
        .cfg      (acfg)
    );

    lbc_timing_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .setup       (acfg.setup),
        .wait_cnt    (acfg.wait_cnt),
        .hold        (acfg.hold),
        .bs_hold     (acfg.bs_hold),
        .rdy_n       (bus_rdy_n),
        .state       (state),
        .strobe_last (strobe_last),
        .last_cycle  (last_cycle),
        .bs_act      (bs_act)
    );

    lbc_lane_ctrl u_lane (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .miss        (miss),
        .write       (req_write),
        .be          (req_be),
        .width       (acfg.width),
        .strobe      (state == ST_STROBE),
        .strobe_last (strobe_last),
        .bus_rdata   (bus_rdata),
        .rd_n        (bus_rd_n),
        .we_n        (bus_we_n),
        .rdata       (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            area_q    <= '0;
            done      <= 1'b0;
        end else begin
            done <= last_cycle || miss;
            if (accept) begin
                bus_addr  <= req_addr;
                bus_wdata <= req_wdata;
                area_q    <= req_addr[AREA_SEL_LSB +: AREA_SEL_W];
            end
        end
    end

    for (genvar k = 0; k < NUM_AREAS; k++) begin : g_cs
        assign bus_cs_n[k] = !(busy && (area_q == AREA_SEL_W'(k)));
    end

    assign bus_bs_n = !bs_act;

endmodule

// File: rtl/lbc_chk.sv
module lbc_chk #(
    parameter int NUM_AREAS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_AREAS-1:0] bus_cs_n,
    input logic                 bus_rd_n,
    input logic [3:0]           bus_we_n,
    input logic                 bus_bs_n,
    input logic                 req_ready,
    input logic                 done,
    input logic [28:0]          bus_addr,
    input logic [31:0]          bus_wdata
);

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bus_cs_n == {NUM_AREAS{1'b1}}));

    // R8
    rd_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && (bus_we_n != 4'hF)));

    // R10
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || (bus_we_n != 4'hF)) |-> (!req_ready && (bus_cs_n != {NUM_AREAS{1'b1}})));

    // R7
    bs_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_bs_n |-> (bus_cs_n != {NUM_AREAS{1'b1}}));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

    // R12
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !$past(req_ready)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

endmodule

bind sram_bus_ctrl lbc_chk #(.NUM_AREAS(NUM_AREAS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_we_n  (bus_we_n),
    .bus_bs_n  (bus_bs_n),
    .req_ready (req_ready),
    .done      (done),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [28:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        done;
    logic [31:0] rdata;
    logic [27:0] cfg_area = '0;
    logic [28:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic [1:0]  bus_cs_n;
    logic        bus_rd_n;
    logic [3:0]  bus_we_n;
    logic        bus_bs_n;
    logic        bus_rdy_n = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    sram_bus_ctrl #(.NUM_AREAS(2)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .cfg_area(cfg_area),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
        .bus_bs_n(bus_bs_n), .bus_rdy_n(bus_rdy_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] lanes(input logic [1:0] wd);
        return (wd == 2'b00) ? 4'b0001 : (wd == 2'b01) ? 4'b0011 : 4'b1111;
    endfunction

    function automatic logic [31:0] expand(input logic [3:0] m);
        return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    // field layout of R11
    function automatic logic [13:0] mk_cfg(input int s, input int w, input int h,
                                           input logic b, input logic [1:0] wd);
        return {wd, b, 3'(h), 5'(w), 3'(s)};
    endfunction

    task automatic run_access(input logic [2:0] sel, input logic wr, input logic [3:0] be,
                              input int s, input int wf, input int h, input logic bsh,
                              input logic [1:0] wd, input int x);
        int we_eff, ext, n, done_at;
        int e_cs, e_setup, e_stb, e_hold, e_bs, e_lane, e_addr, e_rdy;
        bit mapped;
        logic [3:0]  m;
        logic [28:0] a;
        logic [31:0] wdat, rpat;
        string len_tag;

        mapped = (sel < 3'd2);
        we_eff = (wf > 25) ? 25 : wf;
        ext    = (we_eff > 0) ? x : 0;
        n      = mapped ? (s + we_eff + 1 + ext + h) : 0;
        m      = lanes(wd);
        seed   = seed * 32'd1103515245 + 32'd12345;
        a      = {sel, seed[25:0]};
        wdat   = ~seed;
        rpat   = {seed[15:0], seed[31:16]};
        len_tag = (wf > 25) ? "R11" : (x > 0) ? "R5" : "R4";
        e_cs = 0; e_setup = 0; e_stb = 0; e_hold = 0; e_bs = 0;
        e_lane = 0; e_addr = 0; e_rdy = 0; done_at = 0;

        @(negedge clk);
        cfg_area  = {2{mk_cfg(s, wf, h, bsh, wd)}};
        req_addr  = a;
        req_write = wr;
        req_be    = be;
        req_wdata = wdat;
        bus_rdata = rpat;
        req_valid = 1'b1;
        check(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);

        for (int i = 1; i <= n + 4 && done_at == 0; i++) begin
            @(negedge clk);
            if (i == 1) req_valid = 1'b0;
            if (we_eff == 0) bus_rdy_n = (x > 0);
            else             bus_rdy_n = (i > s) && (i <= s + we_eff + x);
            #1;
            if (done) begin
                done_at = i;
            end else if (i <= n) begin
                bit exp_stb, vis, act_stb, exp_bs;
                logic [3:0] exp_we;
                exp_stb = (i > s) && (i <= s + we_eff + 1 + ext);
                vis     = exp_stb && (!wr || ((be & m) != 4'h0));
                act_stb = !bus_rd_n || (bus_we_n != 4'hF);
                exp_bs  = (i == 1) || (i == 2 && bsh && s > 0);
                exp_we  = (exp_stb && wr) ? ~(be & m) : 4'hF;
                if (bus_cs_n != ~(2'b01 << sel[0]) && e_cs == 0) e_cs = i;
                if (act_stb != vis) begin
                    if (i <= s) begin
                        if (e_setup == 0) e_setup = i;
                    end else if (exp_stb) begin
                        if (e_stb == 0) e_stb = i;
                    end else if (e_hold == 0) e_hold = i;
                end
                if ((!bus_bs_n) != exp_bs && e_bs == 0) e_bs = i;
                if ((bus_we_n != exp_we || bus_rd_n != !(exp_stb && !wr)) && e_lane == 0) e_lane = i;
                if ((bus_addr != a || bus_wdata != wdat) && e_addr == 0) e_addr = i;
                if (req_ready && e_rdy == 0) e_rdy = i;
            end
        end
        bus_rdy_n = 1'b0;

        check(done_at == n + 1, mapped ? len_tag : "R2", "done cycle", done_at, n + 1);
        if (mapped) begin
            check(e_cs == 0, "R1", "chip select bad at cycle", e_cs, 0);
            check(e_setup == 0, "R3", "strobe in setup at cycle", e_setup, 0);
            check(e_stb == 0, len_tag, "strobe missing at cycle", e_stb, 0);
            check(e_hold == 0, "R6", "strobe in hold at cycle", e_hold, 0);
            check(e_bs == 0, "R7", "bus-start bad at cycle", e_bs, 0);
            check(e_lane == 0, wr ? "R9" : "R8", "strobe lanes bad at cycle", e_lane, 0);
            check(e_addr == 0, "R12", "address/data moved at cycle", e_addr, 0);
            check(e_rdy == 0, "R10", "ready high while busy at cycle", e_rdy, 0);
            if (!wr) check(rdata == (rpat & expand(m)), "R8", "read data", rdata, rpat & expand(m));
        end else begin
            check(rdata == 32'h0, "R2", "unmapped read data", rdata, 0);
        end
        check(bus_cs_n == 2'b11 && bus_rd_n && bus_we_n == 4'hF, mapped ? "R6" : "R2",
              "bus idle with done", {bus_cs_n, bus_rd_n, bus_we_n}, 7'h7F);
        @(negedge clk);
        #1;
        check(done == 1'b0, "R10", "done pulse width", done, 0);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(req_ready && !done && bus_cs_n == 2'b11 && bus_rd_n && bus_we_n == 4'hF && bus_bs_n,
              "R10", "reset state", {req_ready, done, bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n},
              {1'b1, 1'b0, 2'b11, 1'b1, 4'hF, 1'b1});

        // timing sweep: every setup and hold, several waits, ready patterns (R3-R7)
        for (int s = 0; s < 8; s++) begin
            for (int h = 0; h < 8; h++) begin
                for (int wi = 0; wi < 4; wi++) begin
                    int wv;
                    wv = (wi == 0) ? 0 : (wi == 1) ? 1 : (wi == 2) ? 4 : 25;
                    run_access(3'((s + h) % 2), 1'(h % 2), 4'hF, s, wv, h,
                               1'((s + h + wi) % 2), 2'b10, (s + wi) % 3);
                end
            end
        end

        // lane sweep over width codes and byte enables (R8, R9)
        for (int wd = 0; wd < 4; wd++) begin
            for (int be = 0; be < 16; be++) begin
                run_access(3'(be % 2), 1'b1, 4'(be), 1, 1, 1, 1'b0, 2'(wd), 0);
                run_access(3'(be % 2), 1'b0, 4'(be), 0, 0, 0, 1'b1, 2'(wd), 1);
            end
        end

        // wait clamp (R11)
        run_access(3'd0, 1'b0, 4'hF, 2, 31, 1, 1'b1, 2'b10, 0);
        run_access(3'd1, 1'b1, 4'hF, 0, 28, 3, 1'b0, 2'b01, 2);

        // unmapped areas (R2)
        for (int sel = 2; sel < 8; sel++) begin
            run_access(3'd0, 1'b0, 4'hF, 0, 0, 0, 1'b0, 2'b10, 0);
            run_access(3'(sel), 1'b0, 4'hF, 3, 5, 2, 1'b1, 2'b10, 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule